// File: doc/BRIEF.md
# Timer Channel Compare/Capture Mode Controller

This block is a single channel of a general-purpose timer. It either produces a pulse-width-modulated output by comparing an external free-running count against a compare value, or acts as an input capture that records the count when a rising edge arrives on one of several selectable sources. A two-bit source field chooses between the two roles. In the capture role it also picks the input: the channel's own pin, the pin of the neighbouring channel, or the timer's internal trigger.

The channel is built around a small state machine with four states. ST_OFF means the channel is disabled. ST_CMP is the compare (output) role. ST_FORCE is a one-cycle state entered through the fast trigger path. ST_CAP is the capture role. The transitions are:
- ST_OFF to ST_CMP when the channel is enabled with source 00.
- ST_OFF to ST_CAP when it is enabled with any other source.
- ST_CMP to ST_FORCE on a fast trigger edge.
- ST_FORCE back to ST_CMP after one cycle.
- Any state to ST_OFF when the enable drops.

The compare value can be double-buffered: with preload on, a new value waits for an update strobe before it takes effect.

Trigger and capture inputs pass through a two-flop synchronizer followed by an edge detector. The output is registered. As a result, a fast trigger reaches the output on the third clock edge after the input rises. When the trigger path is not used, the count-to-output path takes two edges. Added to the three-edge synchronizer, that gives a minimum of five edges from a trigger that restarts the external counter.

Top module: `ccm_chan`

## Requirements
- R1: After reset, `oc` is 0, `cap_flag` is 0 and `cap_val` is 0. The stored source field is 00, the output mode is 00 and the compare value is 0.
- R2: When the channel is enabled with source 00, the output mode field (00 low, 01 high, 10 PWM1, 11 PWM2) drives `oc`. In PWM1, `oc` is 1 while `cnt` < compare and 0 otherwise. PWM2 is the inverse. A change on `cnt` reaches `oc` on the second rising edge.
- R3: Mode 00 holds `oc` at 0 and mode 01 holds it at 1, whatever the count.
- R4: With preload off, a compare write takes effect at the write edge. With preload on, the written value takes effect only at an `upd` strobe.
- R5: With fast enable set and mode PWM1 or PWM2, a rising `trg_in` sets `oc` to the match level for exactly one cycle. The match level is 0 for PWM1 and 1 for PWM2. The change appears on the third rising edge after `trg_in` rises; the compare output then resumes.
- R6: With fast enable clear, a `trg_in` edge has no effect on `oc`.
- R7: With fast enable set but mode 00 or 01, a `trg_in` edge has no effect on `oc`.
- R8: With source 01, a rising edge on `pin_own` latches `cnt` into `cap_val` and sets `cap_flag` on the third rising edge after the pin rises. `oc` stays 0 in capture.
- R9: With source 10, capture uses `pin_nbr`, and edges on `pin_own` are ignored.
- R10: With source 11, capture uses `trg_in` only while `trg_ok` is 1. Otherwise the capture input is held inactive.
- R11: A one-cycle `flag_clr` clears `cap_flag` unless a capture occurs in the same cycle.
- R12: A configuration write changes the source field only while `chan_en` is 0. The other fields are always written.
- R13: While `chan_en` is 0, `oc` is 0 and no capture occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | W | Free-running timer count |
| upd | input | 1 | Update event, loads the preloaded compare value |
| chan_en | input | 1 | Channel enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Source field: 00 output, 01 own pin, 10 neighbour pin, 11 trigger |
| cfg_mode | input | 2 | Output mode: 00 low, 01 high, 10 PWM1, 11 PWM2 |
| cfg_fast | input | 1 | Fast trigger enable |
| cfg_pre | input | 1 | Compare preload enable |
| cmp_we | input | 1 | Compare write strobe |
| cmp_wdata | input | W | Compare write value |
| pin_own | input | 1 | This channel's pin input |
| pin_nbr | input | 1 | Neighbouring channel's pin input |
| trg_in | input | 1 | Internal trigger signal |
| trg_ok | input | 1 | Internal trigger source has been selected |
| flag_clr | input | 1 | Write-one-to-clear strobe for the capture flag |
| oc | output | 1 | Channel output |
| cap_val | output | W | Captured count |
| cap_flag | output | 1 | Capture occurred |

## Verification
The bench times the fast path edge by edge, expecting the forced level on the third edge and no earlier. A design with a missing or extra synchronizer stage, or one that forces the output for longer or to the wrong level, would miss that window.

Trigger edges are also sent with fast enable clear and in the non-PWM modes. A design that ignores the mode gate would glitch the output in those cases.

Capture is exercised from each source. The bench checks that edges on the unselected pins, and trigger edges while no trigger source is valid, leave the flag clear. A design that mis-decodes the source field would capture on the wrong input.

A source write while the channel is enabled must not turn the channel into an output. The preload test checks that the new compare value waits for the update strobe, so a design that bypasses the shadow register would change the duty early.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
    typedef enum logic [1:0] {
        SEL_OUT = 2'b00,
        SEL_OWN = 2'b01,
        SEL_NBR = 2'b10,
        SEL_TRG = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        OM_LOW  = 2'b00,
        OM_HIGH = 2'b01,
        OM_PWM1 = 2'b10,
        OM_PWM2 = 2'b11
    } omode_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_CMP   = 2'b01,
        ST_FORCE = 2'b10,
        ST_CAP   = 2'b11
    } st_e;
endpackage

// File: rtl/ccm_edge.sv
module ccm_edge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise
);
    logic [SYNC:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SYNC-1:0], d};
    end

    assign rise = sh[SYNC-1] & ~sh[SYNC];
endmodule

// File: rtl/ccm_cfg.sv
module ccm_cfg
    import ccm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         chan_en,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_sel,
    input  logic [1:0]   cfg_mode,
    input  logic         cfg_fast,
    input  logic         cfg_pre,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         upd,
    output sel_e         sel_q,
    output omode_e       mode_q,
    output logic         fast_q,
    output logic [W-1:0] cmp_act
);
    logic         pre_q;
    logic [W-1:0] cmp_shadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= SEL_OUT;
            mode_q <= OM_LOW;
            fast_q <= 1'b0;
            pre_q  <= 1'b0;
        end else if (cfg_we) begin
            if (!chan_en) sel_q <= sel_e'(cfg_sel);
            mode_q <= omode_e'(cfg_mode);
            fast_q <= cfg_fast;
            pre_q  <= cfg_pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_shadow <= '0;
            cmp_act    <= '0;
        end else begin
            if (cmp_we) cmp_shadow <= cmp_wdata;
            if (pre_q) begin
                if (upd) cmp_act <= cmp_shadow;
            end else if (cmp_we) begin
                cmp_act <= cmp_wdata;
            end
        end
    end
endmodule

// File: rtl/ccm_chan.sv
module ccm_chan
    import ccm_pkg::*;
#(
    parameter int W    = 16,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic         upd,
    input  logic         chan_en,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_sel,
    input  logic [1:0]   cfg_mode,
    input  logic         cfg_fast,
    input  logic         cfg_pre,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         pin_own,
    input  logic         pin_nbr,
    input  logic         trg_in,
    input  logic         trg_ok,
    input  logic         flag_clr,
    output logic         oc,
    output logic [W-1:0] cap_val,
    output logic         cap_flag
);
    sel_e         sel_q;
    omode_e       mode_q;
    logic         fast_q;
    logic [W-1:0] cmp_act;
    logic [W-1:0] cnt_q;
    logic         cap_src, cap_rise, trg_rise, hit, oc_d;
    st_e          state_q, state_n;

    ccm_cfg #(.W(W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_mode(cfg_mode), .cfg_fast(cfg_fast),
        .cfg_pre(cfg_pre), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .upd(upd), .sel_q(sel_q), .mode_q(mode_q), .fast_q(fast_q),
        .cmp_act(cmp_act)
    );

    always_comb begin
        unique case (sel_q)
            SEL_OWN: cap_src = pin_own;
            SEL_NBR: cap_src = pin_nbr;
            SEL_TRG: cap_src = trg_in & trg_ok;
            default: cap_src = 1'b0;
        endcase
    end

    ccm_edge #(.SYNC(SYNC)) u_cap_edge (
        .clk(clk), .rst_n(rst_n), .d(cap_src), .rise(cap_rise)
    );
    ccm_edge #(.SYNC(SYNC)) u_trg_edge (
        .clk(clk), .rst_n(rst_n), .d(trg_in), .rise(trg_rise)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt;
    end

    assign hit = (cnt_q < cmp_act);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_OFF:   if (chan_en) state_n = (sel_q == SEL_OUT) ? ST_CMP : ST_CAP;
            ST_CMP:   if (!chan_en) state_n = ST_OFF;
                      else if (fast_q && mode_q[1] && trg_rise) state_n = ST_FORCE;
            ST_FORCE: state_n = chan_en ? ST_CMP : ST_OFF;
            ST_CAP:   if (!chan_en) state_n = ST_OFF;
            default:  state_n = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        oc_d = 1'b0;
        unique case (state_n)
            ST_CMP: begin
                unique case (mode_q)
                    OM_LOW:  oc_d = 1'b0;
                    OM_HIGH: oc_d = 1'b1;
                    OM_PWM1: oc_d = hit;
                    OM_PWM2: oc_d = ~hit;
                    default: oc_d = 1'b0;
                endcase
            end
            ST_FORCE: oc_d = (mode_q == OM_PWM2);
            default:  oc_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oc       <= 1'b0;
            cap_val  <= '0;
            cap_flag <= 1'b0;
        end else begin
            oc <= oc_d;
            if (state_q == ST_CAP && cap_rise) begin
                cap_val  <= cnt;
                cap_flag <= 1'b1;
            end else if (flag_clr) begin
                cap_flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ccm_chk.sv
module ccm_chk
    import ccm_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         chan_en,
    input logic         oc,
    input logic [W-1:0] cap_val,
    input logic         cap_flag,
    input logic         flag_clr,
    input logic         cap_rise,
    input sel_e         sel_q,
    input omode_e       mode_q,
    input st_e          state_q
);
    p_off_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!chan_en) |-> !oc);

    p_capval_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_val) |-> cap_flag);

    p_cap_no_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAP) |-> !oc);

    p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flag_clr && !(cap_rise && state_q == ST_CAP)) |-> !cap_flag);

    p_sel_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chan_en) |-> $stable(sel_q));

    p_force_pwm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FORCE) |-> $past(mode_q[1]));
endmodule

bind ccm_chan ccm_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .oc(oc),
    .cap_val(cap_val), .cap_flag(cap_flag), .flag_clr(flag_clr),
    .cap_rise(cap_rise), .sel_q(sel_q), .mode_q(mode_q), .state_q(state_q)
);

// File: tb/sim_ccm_chan.sv
module sim_ccm_chan;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt = '0;
    logic         upd = 1'b0, chan_en = 1'b0, cfg_we = 1'b0;
    logic [1:0]   cfg_sel = 2'b00, cfg_mode = 2'b00;
    logic         cfg_fast = 1'b0, cfg_pre = 1'b0, cmp_we = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         pin_own = 1'b0, pin_nbr = 1'b0, trg_in = 1'b0, trg_ok = 1'b0;
    logic         flag_clr = 1'b0;
    logic         oc, cap_flag;
    logic [W-1:0] cap_val;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ccm_chan #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .upd(upd), .chan_en(chan_en),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_mode(cfg_mode),
        .cfg_fast(cfg_fast), .cfg_pre(cfg_pre), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .pin_own(pin_own), .pin_nbr(pin_nbr),
        .trg_in(trg_in), .trg_ok(trg_ok), .flag_clr(flag_clr), .oc(oc),
        .cap_val(cap_val), .cap_flag(cap_flag)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [1:0] s, input logic [1:0] m,
                             input logic f, input logic p);
        cfg_sel = s; cfg_mode = m; cfg_fast = f; cfg_pre = p; cfg_we = 1'b1;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic write_cmp(input logic [W-1:0] v);
        cmp_wdata = v; cmp_we = 1'b1;
        tick(1);
        cmp_we = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 oc", oc, 0);
        chk("R1 cap_flag", cap_flag, 0);
        chk("R1 cap_val", cap_val, 0);
    endtask

    task automatic t_disabled;
        write_cfg(2'b00, 2'b01, 1'b0, 1'b0);
        tick(3);
        chk("R13 oc low while disabled", oc, 0);
        write_cfg(2'b01, 2'b00, 1'b0, 1'b0);
        cnt = 16'd7; pin_own = 1'b1;
        tick(4);
        chk("R13 no capture while disabled", cap_flag, 0);
        pin_own = 1'b0;
        write_cfg(2'b00, 2'b00, 1'b0, 1'b0);
        tick(3);
    endtask

    task automatic t_pwm;
        write_cmp(16'd10);
        write_cfg(2'b00, 2'b10, 1'b0, 1'b0);
        cnt = 16'd5; chan_en = 1'b1;
        tick(3);
        chk("R2 PWM1 below compare", oc, 1);
        cnt = 16'd12;
        tick(1);
        chk("R2 PWM1 one edge unchanged", oc, 1);
        tick(1);
        chk("R2 PWM1 at/above compare", oc, 0);
        cnt = 16'd10;
        tick(2);
        chk("R2 PWM1 equal compare", oc, 0);
        write_cfg(2'b00, 2'b11, 1'b0, 1'b0);
        tick(1);
        chk("R2 PWM2 at compare", oc, 1);
        cnt = 16'd3;
        tick(2);
        chk("R2 PWM2 below compare", oc, 0);
    endtask

    task automatic t_force_modes;
        write_cfg(2'b00, 2'b00, 1'b0, 1'b0);
        tick(1);
        chk("R3 mode 00 low", oc, 0);
        write_cfg(2'b00, 2'b01, 1'b0, 1'b0);
        cnt = 16'd50;
        tick(2);
        chk("R3 mode 01 high", oc, 1);
    endtask

    task automatic t_preload;
        cnt = 16'd15;
        write_cfg(2'b00, 2'b10, 1'b0, 1'b0);
        write_cmp(16'd20);
        tick(1);
        chk("R4 immediate compare write", oc, 1);
        write_cfg(2'b00, 2'b10, 1'b0, 1'b1);
        write_cmp(16'd10);
        tick(3);
        chk("R4 preload holds old value", oc, 1);
        upd = 1'b1;
        tick(1);
        upd = 1'b0;
        tick(1);
        chk("R4 preload applied at update", oc, 0);
        write_cfg(2'b00, 2'b10, 1'b0, 1'b0);
    endtask

    task automatic t_fast;
        write_cmp(16'd10);
        cnt = 16'd5;
        write_cfg(2'b00, 2'b11, 1'b1, 1'b0);
        tick(2);
        chk("R5 PWM2 idle low", oc, 0);
        trg_in = 1'b1;
        tick(2);
        chk("R5 not forced after two edges", oc, 0);
        tick(1);
        chk("R5 PWM2 forced high on third edge", oc, 1);
        tick(1);
        chk("R5 force lasts one cycle", oc, 0);
        trg_in = 1'b0;
        write_cfg(2'b00, 2'b10, 1'b1, 1'b0);
        tick(3);
        chk("R5 PWM1 idle high", oc, 1);
        trg_in = 1'b1;
        tick(3);
        chk("R5 PWM1 forced low", oc, 0);
        tick(1);
        chk("R5 PWM1 resumes", oc, 1);
        trg_in = 1'b0;
        tick(3);
    endtask

    task automatic t_fast_off;
        logic seen;
        write_cfg(2'b00, 2'b11, 1'b0, 1'b0);
        tick(3);
        seen = 1'b0;
        trg_in = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            seen = seen | oc;
        end
        chk("R6 fast clear ignores trigger", seen, 0);
        trg_in = 1'b0;
        write_cfg(2'b00, 2'b00, 1'b1, 1'b0);
        tick(3);
        seen = 1'b0;
        trg_in = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            seen = seen | oc;
        end
        chk("R7 fast ignored in mode 00", seen, 0);
        trg_in = 1'b0;
        tick(3);
    endtask

    task automatic t_cap_own;
        chan_en = 1'b0;
        tick(1);
        write_cfg(2'b01, 2'b01, 1'b0, 1'b0);
        chan_en = 1'b1;
        tick(2);
        cnt = 16'd33; pin_own = 1'b1;
        tick(2);
        chk("R8 flag not yet set", cap_flag, 0);
        tick(1);
        chk("R8 flag set on third edge", cap_flag, 1);
        chk("R8 captured count", cap_val, 33);
        chk("R8 output low in capture", oc, 0);
        pin_own = 1'b0;
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        chk("R11 flag cleared", cap_flag, 0);
        tick(3);
    endtask

    task automatic t_lock;
        write_cfg(2'b00, 2'b01, 1'b0, 1'b0);
        tick(2);
        chk("R12 still capture after locked write", oc, 0);
        cnt = 16'd44; pin_own = 1'b1;
        tick(3);
        chk("R12 source unchanged, capture works", cap_val, 44);
        pin_own = 1'b0;
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        tick(3);
    endtask

    task automatic t_cap_nbr;
        chan_en = 1'b0;
        tick(1);
        write_cfg(2'b10, 2'b00, 1'b0, 1'b0);
        chan_en = 1'b1;
        tick(2);
        cnt = 16'd61; pin_own = 1'b1;
        tick(4);
        chk("R9 own pin ignored", cap_flag, 0);
        pin_own = 1'b0;
        cnt = 16'd62; pin_nbr = 1'b1;
        tick(3);
        chk("R9 neighbour pin flag", cap_flag, 1);
        chk("R9 neighbour pin value", cap_val, 62);
        pin_nbr = 1'b0;
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        tick(3);
    endtask

    task automatic t_cap_trg;
        chan_en = 1'b0;
        tick(1);
        write_cfg(2'b11, 2'b00, 1'b0, 1'b0);
        chan_en = 1'b1;
        trg_ok = 1'b0;
        tick(2);
        cnt = 16'd70; trg_in = 1'b1;
        tick(4);
        chk("R10 trigger blocked without valid source", cap_flag, 0);
        trg_in = 1'b0;
        tick(3);
        trg_ok = 1'b1;
        tick(3);
        cnt = 16'd71; trg_in = 1'b1;
        tick(3);
        chk("R10 trigger capture flag", cap_flag, 1);
        chk("R10 trigger capture value", cap_val, 71);
        trg_in = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_disabled();
        t_pwm();
        t_force_modes();
        t_preload();
        t_fast();
        t_fast_off();
        t_cap_own();
        t_lock();
        t_cap_nbr();
        t_cap_trg();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule